// File: doc/BRIEF.md
# USB Interrupt Status Register

This block keeps the sticky interrupt flags of a dual-role USB controller and drives its single interrupt request. Five conditions are tracked: a change of the VBUS level, a resume signalled by D+ falling while the device is suspended, a frame-number update, a change of the device state, and a change of the control-transfer stage. Each flag has its own enable bit, and the interrupt line is the OR of every flag whose enable is set.

Software sees two 16-bit registers behind a one-bit address. A flag is cleared by writing 0 to its bit while writing 1 to all the others, so a read-modify-write can never wipe a flag that arrived in the meantime. The block runs on one free-running clock. A core enable input marks the cycles in which the core clock would run. The VBUS and resume detectors, their flags and the interrupt line keep working while that enable is low. Register writes and the three core-side flags do not.

VBUS and D+ are raw pins. They pass through a synchronizer before edge detection. The current synchronized VBUS level is mirrored both on an output and in a read-only status bit.

Top module: `usb_irq_status`

## Requirements
- R1: A write to the status register (address 0) while `core_en` is 1 clears each flag whose data bit is 0; a flag whose data bit is 1 keeps its value.
- R2: When a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R3: Every rising and every falling transition of `vbus_pin` sets the VBUS-change flag (status bit 0). The flag is readable after the third rising clock edge that follows the pin change.
- R4: `vbus_lvl` and status bit 8 show the synchronized VBUS level one clock edge before the change flag sets, which is two edges after the pin changes.
- R5: A falling edge of `dp_pin` sets the resume flag (status bit 1) only when `role_periph` is 1 and `dev_state[2]` is 1 (suspend). The flag is readable after the third edge that follows the pin fall.
- R6: While `role_periph` is 0, the resume, device-state (bit 3) and control-stage (bit 4) flags never set.
- R7: In peripheral role with `core_en` at 1, the device-state flag (bit 3) sets at the edge where `dev_state` differs from the value it held at the last enabled edge.
- R8: With `core_en` at 1, a `frame_evt` pulse sets status bit 2, and a `stage_evt` pulse in peripheral role sets status bit 4, at the same edge.
- R9: While `core_en` is 0, writes to either register and the frame, device-state and stage events have no effect. The VBUS and resume flags still set, and `irq` still follows them.
- R10: `irq` is 1 exactly when some flag and its enable bit (address 1, bits 4:0, in the same order as the flags) are both 1. It stays at that level until the flag is cleared or the enable is removed.
- R11: After reset all flags and enables are 0. A read of address 0 returns the flags in bits 4:0 and the VBUS level in bit 8. A read of address 1 returns the enables in bits 4:0. Every other read bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_en | input | 1 | Core clock enable; 0 means the core domain is gated |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 status, 1 enable |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| vbus_pin | input | 1 | Raw VBUS comparator level |
| dp_pin | input | 1 | Raw D+ line level |
| role_periph | input | 1 | 1 = peripheral role, 0 = host role |
| dev_state | input | 3 | Current device state, bit 2 set means suspend |
| frame_evt | input | 1 | One-cycle pulse on frame-number update |
| stage_evt | input | 1 | One-cycle pulse on control-stage change |
| vbus_lvl | output | 1 | Synchronized VBUS level |
| irq | output | 1 | Level interrupt request |

## Verification
The checker watches every cycle for several things:
- a flag falls only after a write of 0 to its bit while the core enable is high;
- the host role never raises the peripheral-only flags;
- the gated core domain neither raises its flags nor changes its enables;
- a VBUS flag rise always follows a change of the mirrored level;
- a frame event always leaves its flag set;
- the interrupt never asserts without a flag behind it.

Some behaviour needs the bench's scenarios instead. These are the exact latency of the synchronizer, the suspend condition on resume, and the write-1-has-no-effect rule. Also covered there are a device-state change seen only when the core wakes up, and the exact read layout. A per-cycle reference model compared against the read data and the interrupt line covers them.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
   localparam int FLAG_N   = 5;
   localparam int F_VBUS   = 0;
   localparam int F_RESUME = 1;
   localparam int F_FRAME  = 2;
   localparam int F_DSTATE = 3;
   localparam int F_STAGE  = 4;
   localparam int LVL_POS  = 8;

   typedef enum logic {
      REG_STATUS = 1'b0,
      REG_ENABLE = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/usb_irq_sync.sv
// Multi-stage synchronizer for a vector of asynchronous pins.
module usb_irq_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("usb_irq_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/usb_irq_edge.sv
// Edge detector: both edges or falling edge only, picked by parameter.
module usb_irq_edge #(
   parameter bit BOTH_EDGES = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic evt
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= d;
   end

   if (BOTH_EDGES) begin : g_both
      assign evt = d ^ prev_q;
   end else begin : g_fall
      assign evt = prev_q & ~d;
   end
endmodule

// File: rtl/usb_irq_flags.sv
// Sticky flag bank: set wins over a write-zero clear.
module usb_irq_flags #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_en,
   input  logic [N-1:0] keep_bits,
   output logic [N-1:0] flags
);
   logic [N-1:0] keep_mask;

   assign keep_mask = clr_en ? keep_bits : {N{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= set | (flags & keep_mask);
   end
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
   import usb_irq_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ST_W        = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit IRQ_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_en,
   input  logic              wr_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              vbus_pin,
   input  logic              dp_pin,
   input  logic              role_periph,
   input  logic [ST_W-1:0]   dev_state,
   input  logic              frame_evt,
   input  logic              stage_evt,
   output logic              vbus_lvl,
   output logic              irq
);
   localparam int SUSP_BIT = ST_W - 1;

   initial begin
      assert (DATA_W > LVL_POS) else $error("usb_irq_status: DATA_W too small for map");
      assert (ST_W >= 1)        else $error("usb_irq_status: ST_W must be positive");
   end

   logic [1:0]        pins_s;
   logic              dp_s;
   logic              vbus_chg;
   logic              dp_fall;
   logic [FLAG_N-1:0] set_vec;
   logic [FLAG_N-1:0] flag_q;
   logic [FLAG_N-1:0] en_q;
   logic [ST_W-1:0]   dst_prev_q;
   logic              wr_status;
   logic              wr_enable;
   logic              unused_wr_bits;

   assign unused_wr_bits = ^wr_data[DATA_W-1:FLAG_N];

   usb_irq_sync #(.W(2), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({dp_pin, vbus_pin}),
      .q     (pins_s)
   );

   assign vbus_lvl = pins_s[0];
   assign dp_s     = pins_s[1];

   usb_irq_edge #(.BOTH_EDGES(1'b1)) i_vbus_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (vbus_lvl),
      .evt   (vbus_chg)
   );

   usb_irq_edge #(.BOTH_EDGES(1'b0)) i_dp_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (dp_s),
      .evt   (dp_fall)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dst_prev_q <= '0;
      else if (core_en) dst_prev_q <= dev_state;
   end

   always_comb begin
      set_vec           = '0;
      set_vec[F_VBUS]   = vbus_chg;
      set_vec[F_RESUME] = dp_fall & role_periph & dev_state[SUSP_BIT];
      set_vec[F_FRAME]  = core_en & frame_evt;
      set_vec[F_DSTATE] = core_en & role_periph & (dev_state != dst_prev_q);
      set_vec[F_STAGE]  = core_en & role_periph & stage_evt;
   end

   assign wr_status = core_en & wr_en & (addr == REG_STATUS);
   assign wr_enable = core_en & wr_en & (addr == REG_ENABLE);

   usb_irq_flags #(.N(FLAG_N)) i_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set       (set_vec),
      .clr_en    (wr_status),
      .keep_bits (wr_data[FLAG_N-1:0]),
      .flags     (flag_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= '0;
      else if (wr_enable) en_q <= wr_data[FLAG_N-1:0];
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(flag_q & en_q);
      end
      assign irq = irq_q;
   end else begin : g_irq_comb
      assign irq = |(flag_q & en_q);
   end

   always_comb begin
      rd_data = '0;
      if (addr == REG_STATUS) begin
         rd_data[FLAG_N-1:0] = flag_q;
         rd_data[LVL_POS]    = vbus_lvl;
      end else begin
         rd_data[FLAG_N-1:0] = en_q;
      end
   end
endmodule

// File: rtl/usb_irq_status_chk.sv
module usb_irq_status_chk
   import usb_irq_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              core_en,
   input logic              wr_en,
   input logic              addr,
   input logic [FLAG_N-1:0] wr_low,
   input logic              role_periph,
   input logic              frame_evt,
   input logic              vbus_lvl,
   input logic              irq,
   input logic [FLAG_N-1:0] flags,
   input logic [FLAG_N-1:0] en
);
   for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
      AST_CLR_ONLY_BY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(flags[i]) |-> $past(core_en && wr_en && !addr && !wr_low[i])); // R1
   end

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(core_en && frame_evt) |-> flags[F_FRAME]); // R2

   AST_VBUS_EDGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[F_VBUS]) |-> ($past(vbus_lvl) != $past(vbus_lvl, 2))); // R3

   AST_HOST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flags[F_RESUME]) || $rose(flags[F_DSTATE]) || $rose(flags[F_STAGE]))
         |-> $past(role_periph)); // R6

   AST_GATED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(core_en) |-> (!$rose(flags[F_FRAME]) && !$rose(flags[F_DSTATE])
                           && !$rose(flags[F_STAGE]) && $stable(en))); // R9

   if (IRQ_REG) begin : g_irq_reg
      AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> |$past(flags)); // R10
   end else begin : g_irq_comb
      AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
         irq |-> |flags); // R10
   end
endmodule

bind usb_irq_status usb_irq_status_chk #(.IRQ_REG(IRQ_REG)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .core_en     (core_en),
   .wr_en       (wr_en),
   .addr        (addr),
   .wr_low      (wr_data[usb_irq_pkg::FLAG_N-1:0]),
   .role_periph (role_periph),
   .frame_evt   (frame_evt),
   .vbus_lvl    (vbus_lvl),
   .irq         (irq),
   .flags       (flag_q),
   .en          (en_q)
);

// File: tb/test_usb_irq_status.sv
`timescale 1ns/1ps
module test_usb_irq_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_en = 1'b1;
   logic        wr_en = 1'b0;
   logic        addr = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        vbus_pin = 1'b0;
   logic        dp_pin = 1'b0;
   logic        role_periph = 1'b0;
   logic [2:0]  dev_state = '0;
   logic        frame_evt = 1'b0;
   logic        stage_evt = 1'b0;
   logic        vbus_lvl;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   bit running = 0;

   always #10 clk = ~clk;

   usb_irq_status i_usb_irq_status (
      .clk(clk), .rst_n(rst_n), .core_en(core_en), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .vbus_pin(vbus_pin), .dp_pin(dp_pin),
      .role_periph(role_periph), .dev_state(dev_state), .frame_evt(frame_evt),
      .stage_evt(stage_evt), .vbus_lvl(vbus_lvl), .irq(irq)
   );

   // Behavioural reference model: pin histories kept as queues.
   int vq[$];
   int dq[$];
   int m_flags, m_en, m_dprev;

   function automatic void model_reset();
      vq = '{0, 0, 0, 0};
      dq = '{0, 0, 0, 0};
      m_flags = 0; m_en = 0; m_dprev = 0;
   endfunction

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else begin
         int s, keep;
         vq.push_front(int'(vbus_pin)); void'(vq.pop_back());
         dq.push_front(int'(dp_pin));   void'(dq.pop_back());
         s = 0;
         if (vq[2] != vq[3]) s |= 1;
         if (dq[3] == 1 && dq[2] == 0 && role_periph && dev_state[2]) s |= 2;
         if (core_en) begin
            if (frame_evt) s |= 4;
            if (role_periph && int'(dev_state) != m_dprev) s |= 8;
            if (role_periph && stage_evt) s |= 16;
         end
         keep = 31;
         if (core_en && wr_en && addr == 1'b0) keep = int'(wr_data[4:0]);
         m_flags = s | (m_flags & keep);
         if (core_en && wr_en && addr == 1'b1) m_en = int'(wr_data[4:0]);
         if (core_en) m_dprev = int'(dev_state);
      end
   end

   function automatic logic [15:0] exp_rd();
      if (addr == 1'b0) return 16'(m_flags) | (16'(vq[1]) << 8);
      return 16'(m_en);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      #1;
      if (rst_n && running) begin
         chk("R11 model rd_data", 32'(rd_data), 32'(exp_rd()));
         chk("R10 model irq", 32'(irq), 32'((m_flags & m_en) != 0));
      end
   end

   task automatic step();
      @(negedge clk); #3;
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wr(input logic a, input logic [15:0] d);
      wr_en = 1'b1; addr = a; wr_data = d;
      step();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rchk(input string tag, input logic a, input logic [15:0] mask,
                       input logic [15:0] exp);
      addr = a; #1;
      chk(tag, 32'(rd_data & mask), 32'(exp));
   endtask

   task automatic pulse_frame();
      frame_evt = 1'b1; step(); frame_evt = 1'b0;
   endtask

   task automatic pulse_stage();
      stage_evt = 1'b1; step(); stage_evt = 1'b0;
   endtask

   task automatic dp_fall_seq();
      dp_pin = 1'b1; cyc(4); dp_pin = 1'b0; cyc(3);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      running = 1;
      step();
      // R11 reset state
      rchk("R11 reset status", 1'b0, 16'hFFFF, 16'h0000);
      rchk("R11 reset enable", 1'b1, 16'hFFFF, 16'h0000);
      chk("R10 reset irq", 32'(irq), 0);

      // R11 enable register layout
      wr(1'b1, 16'hFFFF);
      rchk("R11 enable reads back bits 4:0 only", 1'b1, 16'hFFFF, 16'h001F);

      // R3/R4 rising VBUS
      addr = 1'b0;
      vbus_pin = 1'b1;
      cyc(2);
      rchk("R4 level after two edges", 1'b0, 16'h0101, 16'h0100);
      chk("R4 vbus_lvl port", 32'(vbus_lvl), 1);
      step();
      rchk("R3 rise sets flag", 1'b0, 16'h0001, 16'h0001);
      chk("R10 irq on enabled flag", 32'(irq), 1);

      // R1 write ones keep, write zero clears
      wr(1'b0, 16'hFFFF);
      rchk("R1 write 1 keeps flag", 1'b0, 16'h0001, 16'h0001);
      wr(1'b0, 16'hFFFE);
      rchk("R1 write 0 clears flag", 1'b0, 16'h0001, 16'h0000);
      chk("R10 irq drops after clear", 32'(irq), 0);

      // R3 falling VBUS
      vbus_pin = 1'b0;
      cyc(3);
      rchk("R3 fall sets flag", 1'b0, 16'h0101, 16'h0001);
      wr(1'b0, 16'hFFFE);

      // R2 set wins over same-cycle clear
      frame_evt = 1'b1;
      wr(1'b0, 16'hFFFB);
      frame_evt = 1'b0;
      rchk("R2 set wins over clear", 1'b0, 16'h0004, 16'h0004);
      wr(1'b0, 16'hFFFB);
      rchk("R8 frame flag cleared", 1'b0, 16'h0004, 16'h0000);

      // R6 host role: peripheral-only flags stay clear
      role_periph = 1'b0;
      dev_state = 3'b101;
      step();
      pulse_stage();
      dp_fall_seq();
      rchk("R6 host role no resume/dstate/stage", 1'b0, 16'h001A, 16'h0000);

      // R7 device-state change in peripheral role
      role_periph = 1'b1;
      step();
      rchk("R7 no set without change", 1'b0, 16'h0008, 16'h0000);
      dev_state = 3'b100;
      step();
      rchk("R7 state change sets flag", 1'b0, 16'h0008, 16'h0008);

      // R5 resume while suspended
      dp_fall_seq();
      rchk("R5 resume in suspend", 1'b0, 16'h0002, 16'h0002);
      wr(1'b0, 16'hFFF5);
      dev_state = 3'b001;
      step();
      wr(1'b0, 16'hFFF7);
      dp_fall_seq();
      rchk("R5 no resume when not suspended", 1'b0, 16'h0002, 16'h0000);

      // R8 stage event
      pulse_stage();
      rchk("R8 stage event sets flag", 1'b0, 16'h0010, 16'h0010);
      wr(1'b0, 16'h0000);
      rchk("R1 clear all", 1'b0, 16'h001F, 16'h0000);

      // R9 gated core domain
      pulse_frame();
      core_en = 1'b0;
      wr(1'b0, 16'h0000);
      rchk("R9 write ignored while gated", 1'b0, 16'h0004, 16'h0004);
      wr(1'b1, 16'h0000);
      rchk("R9 enable write ignored while gated", 1'b1, 16'hFFFF, 16'h001F);
      addr = 1'b0;
      pulse_stage();
      dev_state = 3'b100;
      step();
      rchk("R9 stage/dstate frozen while gated", 1'b0, 16'h0018, 16'h0000);
      core_en = 1'b1;
      wr(1'b0, 16'hFFFF & ~16'h0004);
      rchk("R9 dstate seen on wake", 1'b0, 16'h001F, 16'h0008);
      wr(1'b0, 16'h0000);
      core_en = 1'b0;
      vbus_pin = 1'b1;
      cyc(3);
      rchk("R9 vbus flag while gated", 1'b0, 16'h0001, 16'h0001);
      chk("R9 irq while gated", 32'(irq), 1);
      dp_fall_seq();
      rchk("R9 resume while gated", 1'b0, 16'h0002, 16'h0002);
      core_en = 1'b1;

      // R10 enable masking
      wr(1'b1, 16'h0010);
      chk("R10 masked flags give no irq", 32'(irq), 0);
      wr(1'b1, 16'h0002);
      chk("R10 single enable gives irq", 32'(irq), 1);
      wr(1'b0, 16'hFFFD);
      chk("R10 irq drops when flag cleared", 32'(irq), 0);

      // R11 reserved bits
      rchk("R11 reserved status bits zero", 1'b0, 16'hFEE0, 16'h0000);
      rchk("R11 reserved enable bits zero", 1'b1, 16'hFFE0, 16'h0000);

      cyc(2);
      running = 0;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R11 actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule